// File: doc/BRIEF.md
# Clock-Ready Interrupt Flag Controller

This block gathers the "ready" indications of eight clock sources (three PLLs and five oscillators). It turns each one into a sticky interrupt flag and drives one combined interrupt request. Every ready input is brought into the block's clock domain through a short synchronizer. Its rising edge is the ready event. A flag is set on that event only if the source's interrupt enable is high in that cycle.

Software reads the eight flags from a flag register on a simple register bus. It acknowledges flags by writing ones to a clear register. One source has an extra condition: the internal 16 MHz oscillator, flag bit 3. Its flag is raised only when the oscillator was started by its software enable. When the oscillator runs only because a peripheral asked for its clock, the flag is not raised. A qualifier input tells the block which of the two cases applies.

The flag layout is fixed, because software decodes it:
- bit 7: second audio/sample PLL
- bit 6: first audio/sample PLL
- bit 5: main PLL
- bit 4: external high-speed oscillator
- bit 3: internal 16 MHz oscillator
- bit 2: multi-speed internal oscillator
- bit 1: external low-speed oscillator
- bit 0: internal low-speed oscillator

Top module: `clkrdy_irq_ctrl`

## Requirements
- R1: After reset all flags are 0, the interrupt output is low and both registers read 0.
- R2: A rising edge on ready input i, with enable i high when the edge reaches the flag logic, sets flag bit i. The bit map is 7 second sample PLL, 6 first sample PLL, 5 main PLL, 4 external fast oscillator, 3 internal 16 MHz oscillator, 2 multi-speed oscillator, 1 external slow oscillator, 0 internal slow oscillator. Flags read at bus address 0x1C, bits 7:0, value 1 meaning pending.
- R3: No edge with the enable high means no set. A ready level that stays high does not set the flag again after a clear, and raising an enable while ready is already high sets nothing.
- R4: A write to address 0x20 clears every flag whose write-data bit is 1. Bits written as 0 leave their flags unchanged, and writes to any other address change no flag.
- R5: When a set event and a clear of the same flag fall in the same cycle, the flag ends up set.
- R6: Flag bit 3 is set only if the qualifier input `sw_start_i` is high at the event. With the qualifier low, a ready edge on source 3 leaves the flag clear.
- R7: `irq_o` is high exactly when at least one flag was set one cycle earlier: it rises one cycle after a flag sets and falls one cycle after the last flag clears.
- R8: Lowering an enable after its flag is set does not clear the flag.
- R9: A read of address 0x20 returns 0, and so does a read of any address other than 0x1C.
- R10: With SYNC_STAGES = 2, a ready rise driven before clock edge 1 shows in the flag after edge 3, and in `irq_o` after edge 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ready_i | input | 8 | Ready level of each clock source (asynchronous) |
| irq_en_i | input | 8 | Per-source ready-interrupt enable |
| sw_start_i | input | 1 | High when the internal 16 MHz oscillator was started by software |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte address |
| bus_wdata_i | input | 8 | Write data (clear mask) |
| bus_rdata_o | output | 32 | Read data, combinational |
| irq_o | output | 1 | Combined clock-ready interrupt |

## Verification
The bench builds the block with its defaults: eight sources, two synchronizer stages, the qualifier on bit 3, and registers at 0x1C and 0x20. With two stages the ready-to-flag latency is short and fixed. That lets directed cases place a bus clear in exactly the cycle of a set event, and lets them check each latency edge one by one. Because eight sources give a small state space, the random walk over ready levels, enables, qualifier and clear masks reaches every bit and their combinations. That covers the held-level, late-enable and qualifier-low paths.

// File: rtl/clkrdy_pkg.sv
package clkrdy_pkg;
    localparam int unsigned NUM_SRC  = 8;
    localparam int unsigned QUAL_IDX = 3;
    typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/clkrdy_sync.sv
module clkrdy_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic rdy_i,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = (st_q.chain << 1) | STAGES'(rdy_i);
        st_d.prev  = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rise_o = st_q.chain[STAGES-1] & ~st_q.prev;

    // R2: an event is a single-cycle pulse
    a_r2_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |=> !rise_o);
endmodule

// File: rtl/clkrdy_gate.sv
module clkrdy_gate
    import clkrdy_pkg::*;
(
    input  src_vec_t rise_i,
    input  src_vec_t en_i,
    input  logic     sw_start_i,
    output src_vec_t set_o
);
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
        if (g == QUAL_IDX) begin : g_qual
            assign set_o[g] = rise_i[g] & en_i[g] & sw_start_i;
        end else begin : g_plain
            assign set_o[g] = rise_i[g] & en_i[g];
        end
    end
endmodule

// File: rtl/clkrdy_flags.sv
module clkrdy_flags
    import clkrdy_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_ni,
    input  src_vec_t set_i,
    input  src_vec_t clr_i,
    output src_vec_t flags_o,
    output logic     irq_o
);
    typedef struct packed {
        src_vec_t flags;
        logic     irq;
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.flags = (st_q.flags & ~clr_i) | set_i;
        st_d.irq   = |st_q.flags;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign flags_o = st_q.flags;
    assign irq_o   = st_q.irq;

    // R3: a flag only rises after a set event
    a_r3_no_spurious_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((st_q.flags & ~$past(st_q.flags)) & ~$past(set_i)) == '0);
    // R4: a flag only falls after a clear of that bit
    a_r4_clear_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (($past(st_q.flags) & ~st_q.flags) & ~$past(clr_i)) == '0);
    // R5: set beats clear
    a_r5_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_i != '0) |=> ((st_q.flags & $past(set_i)) == $past(set_i)));
    // R7: combined request follows flags by one cycle
    a_r7_irq_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.flags != '0) |=> irq_o);
    a_r7_irq_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.flags == '0) |=> !irq_o);
endmodule

// File: rtl/clkrdy_regs.sv
module clkrdy_regs
    import clkrdy_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned FLAG_ADDR = 'h1C,
    parameter int unsigned CLR_ADDR  = 'h20
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  src_vec_t          bus_wdata_i,
    input  src_vec_t          flags_i,
    output src_vec_t          clr_o,
    output logic [DATA_W-1:0] bus_rdata_o
);
    localparam logic [ADDR_W-1:0] FlagA = ADDR_W'(FLAG_ADDR);
    localparam logic [ADDR_W-1:0] ClrA  = ADDR_W'(CLR_ADDR);

    logic hit_flag_rd, hit_clr_wr;

    always_comb begin
        hit_flag_rd = bus_sel_i && !bus_wr_i && (bus_addr_i == FlagA);
        hit_clr_wr  = bus_sel_i &&  bus_wr_i && (bus_addr_i == ClrA);
        clr_o       = hit_clr_wr ? bus_wdata_i : '0;
        bus_rdata_o = hit_flag_rd ? DATA_W'(flags_i) : '0;
    end

    // R9: the clear register reads as zero
    a_r9_clr_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_sel_i && !bus_wr_i && bus_addr_i == ClrA) |-> (bus_rdata_o == '0));
endmodule

// File: rtl/clkrdy_irq_ctrl.sv
module clkrdy_irq_ctrl
    import clkrdy_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned FLAG_ADDR   = 'h1C,
    parameter int unsigned CLR_ADDR    = 'h20
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] ready_i,
    input  logic [NUM_SRC-1:0] irq_en_i,
    input  logic               sw_start_i,
    input  logic               bus_sel_i,
    input  logic               bus_wr_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [NUM_SRC-1:0] bus_wdata_i,
    output logic [DATA_W-1:0]  bus_rdata_o,
    output logic               irq_o
);
    src_vec_t rise, set_vec, clr_vec, flags;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_sync
        clkrdy_sync #(.STAGES(SYNC_STAGES)) i_sync (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .rdy_i  (ready_i[g]),
            .rise_o (rise[g])
        );
    end

    clkrdy_gate i_gate (
        .rise_i     (rise),
        .en_i       (irq_en_i),
        .sw_start_i (sw_start_i),
        .set_o      (set_vec)
    );

    clkrdy_flags i_flags (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .set_i   (set_vec),
        .clr_i   (clr_vec),
        .flags_o (flags),
        .irq_o   (irq_o)
    );

    clkrdy_regs #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .FLAG_ADDR (FLAG_ADDR),
        .CLR_ADDR  (CLR_ADDR)
    ) i_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .bus_sel_i   (bus_sel_i),
        .bus_wr_i    (bus_wr_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .flags_i     (flags),
        .clr_o       (clr_vec),
        .bus_rdata_o (bus_rdata_o)
    );

    // R6: a flag-3 event needs the software-start qualifier
    a_r6_qual_needed: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_vec[QUAL_IDX] |-> sw_start_i);
    // R3: events only pass where the enable is high
    a_r3_enable_needed: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_vec & ~irq_en_i) == '0);
endmodule

// File: tb/test_clkrdy_irq_ctrl.sv
module test_clkrdy_irq_ctrl;
    localparam logic [7:0] FLAG_A = 8'h1C;
    localparam logic [7:0] CLR_A  = 8'h20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ready = '0, en = '0, wdata = '0, addr = '0;
    logic        qual = 1'b0, sel = 1'b0, wr = 1'b0;
    logic [31:0] rdata;
    logic        irq;

    int total = 0, bad = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    clkrdy_irq_ctrl i_clkrdy_irq_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .ready_i(ready), .irq_en_i(en),
        .sw_start_i(qual), .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; wdata = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1 d = rdata;
        sel = 1'b0;
    endtask

    function automatic logic [7:0] model_set(input logic [7:0] prev, input logic [7:0] nxt,
                                            input logic [7:0] e, input logic q);
        logic [7:0] s;
        s = nxt & ~prev & e;
        if (!q) s[3] = 1'b0;
        return s;
    endfunction

    task automatic clear_all();
        @(negedge clk); ready = '0;
        idle(6);
        bus_write(CLR_A, 8'hFF);
        idle(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [7:0]  exp;
        void'($urandom(32'hC10C));
        idle(3);
        // R1: reset state
        bus_read(FLAG_A, d); check("R1 flags after reset", d, 0);
        check("R1 irq after reset", {31'b0, irq}, 0);
        rst_n = 1'b1;
        idle(2);
        bus_read(FLAG_A, d); check("R1 flags after release", d, 0);
        bus_read(CLR_A, d);  check("R1 clear reg reads", d, 0);

        // R10 / R7: latency of one ready rise
        en = 8'hFF; qual = 1'b1;
        @(negedge clk); ready[0] = 1'b1;
        idle(1); bus_read(FLAG_A, d); check("R10 after edge1", d, 0);
        idle(1); bus_read(FLAG_A, d); check("R10 after edge2", d, 0);
        idle(1); bus_read(FLAG_A, d); check("R10 after edge3", d, 32'h01);
        check("R7 irq one cycle late", {31'b0, irq}, 0);
        idle(1); check("R7 irq raised", {31'b0, irq}, 1);

        // R3: held level does not re-set after clear
        bus_write(CLR_A, 8'h01);
        bus_read(FLAG_A, d); check("R4 bit0 cleared", d, 0);
        check("R7 irq still high one cycle", {31'b0, irq}, 1);
        idle(1); check("R7 irq falls", {31'b0, irq}, 0);
        idle(6); bus_read(FLAG_A, d); check("R3 held level no re-set", d, 0);

        // R3: enable low at event, then late enable
        @(negedge clk); en[1] = 1'b0; ready[1] = 1'b1;
        idle(6); bus_read(FLAG_A, d); check("R3 disabled event", d, 0);
        en[1] = 1'b1;
        idle(6); bus_read(FLAG_A, d); check("R3 late enable no set", d, 0);

        // R8: disabling after set keeps flag
        @(negedge clk); ready[2] = 1'b1;
        idle(6); en[2] = 1'b0;
        idle(4); bus_read(FLAG_A, d); check("R8 flag kept", d, 32'h04);

        // R6: qualifier on bit 3
        @(negedge clk); qual = 1'b0; ready[3] = 1'b1;
        idle(6); bus_read(FLAG_A, d); check("R6 qualifier low", d, 32'h04);
        @(negedge clk); ready[3] = 1'b0;
        idle(6); qual = 1'b1; ready[3] = 1'b1;
        idle(6); bus_read(FLAG_A, d); check("R6 qualifier high", d, 32'h0C);

        // R4: zero bits and other addresses do nothing
        bus_write(CLR_A, 8'h00);
        bus_read(FLAG_A, d); check("R4 zero mask", d, 32'h0C);
        bus_write(8'h24, 8'hFF);
        bus_read(FLAG_A, d); check("R4 other address", d, 32'h0C);
        bus_write(FLAG_A, 8'hFF);
        bus_read(FLAG_A, d); check("R4 write to flag address", d, 32'h0C);
        bus_write(CLR_A, 8'h04);
        bus_read(FLAG_A, d); check("R4 single bit", d, 32'h08);

        // R9: reads elsewhere return zero
        bus_read(8'h00, d); check("R9 other address read", d, 0);
        bus_read(CLR_A, d); check("R9 clear reg with flags set", d, 0);

        // R5: set and clear in the same cycle
        clear_all();
        en = 8'hFF;
        @(negedge clk); ready[4] = 1'b1;
        idle(2);
        sel = 1'b1; wr = 1'b1; addr = CLR_A; wdata = 8'h10;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; wdata = '0;
        bus_read(FLAG_A, d); check("R5 set wins", d, 32'h10);

        // R2: each bit position alone
        for (int i = 0; i < 8; i++) begin
            clear_all();
            en = 8'(1 << i); qual = 1'b1;
            @(negedge clk); ready = 8'hFF;
            idle(6); bus_read(FLAG_A, d);
            check($sformatf("R2 bit %0d position", i), d, 32'(1 << i));
        end

        // random walk: R2 R3 R4 R6 R7
        clear_all();
        exp = '0;
        for (int s = 0; s < 150; s++) begin
            logic [7:0] nr, ne, m;
            logic nq;
            nr = 8'($urandom); ne = 8'($urandom); nq = 1'($urandom);
            exp = exp | model_set(ready, nr, ne, nq);
            @(negedge clk); ready = nr; en = ne; qual = nq;
            idle(6);
            bus_read(FLAG_A, d); check("R2 R3 R6 random flags", d, 32'(exp));
            check("R7 random irq", {31'b0, irq}, {31'b0, |exp});
            if ($urandom % 2 == 1) begin
                m = 8'($urandom);
                bus_write(CLR_A, m);
                exp = exp & ~m;
                bus_read(FLAG_A, d); check("R4 random clear", d, 32'(exp));
                idle(1);
                check("R7 random irq after clear", {31'b0, irq}, {31'b0, |exp});
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule